// File: doc/BRIEF.md
# BCD Calendar Time Converter

This block translates calendar and time-of-day values between plain binary numbers and the packed BCD byte layout that a battery-backed real-time clock keeps in its registers. A host that wants to program the clock hands it binary year, month, day, hour, minute and second values. It gets back the six register bytes. A host that has read those bytes hands them in and gets binary fields back.

One input bit picks the direction. A second input bit picks how the hour byte is laid out: plain 24-hour BCD, or 12-hour BCD with a PM flag. In the encode direction the month byte also carries a century flag, which is set for years from 2000 on. In the decode direction that flag is masked off, and the two-digit year is placed on a fixed epoch of 2000.

Each packed byte holds the tens digit in bits 7:4 and the units digit in bits 3:0. Binary inputs are expected in the range 0 to 99; the full year is the only exception. The result is registered one cycle after a valid input and is flagged by a valid output.

Top module: `rtc_bcd_conv`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid and every enc_* and dec_* output are cleared to zero.
- R2: out_valid is high in the cycle after in_valid was sampled high, and low in the cycle after in_valid was sampled low.
- R3: Encoding (dir_decode=0) turns seconds, minutes and day into BCD bytes of the form {tens[3:0], units[3:0]}, e.g. 59 gives 8'h59 and 9 gives 8'h09.
- R4: Encoding with mode_12h=0 gives an hour byte that is the plain BCD of the hour, 0 to 23, with bit 5 carrying no special meaning.
- R5: Encoding with mode_12h=1 sets bit 5 of the hour byte for hours 12 to 23. Bits 4:0 then hold the BCD of ((h+11) mod 12)+1. So 0 gives 8'h12, 12 gives 8'h32, 13 gives 8'h21 and 23 gives 8'h31.
- R6: Encoding puts the BCD month 1 to 12 in bits 6:0 of the month byte. Bit 7 is set exactly when the binary year is 2000 or more. The year byte is the BCD of the year modulo 100.
- R7: Decoding (dir_decode=1) turns BCD bytes for seconds, minutes and day into binary, tens*10+units.
- R8: Decoding with mode_12h=1 first clears bit 5 of the hour byte and converts the rest from BCD. It takes that value modulo 12, then adds 12 if bit 5 was set. So 8'h12 gives 0, 8'h32 gives 12 and 8'h21 gives 13.
- R9: Decoding with mode_12h=0 converts the whole hour byte as plain BCD.
- R10: Decoding clears bit 7 of the month byte before it converts the month. The decoded year is 2000 plus the BCD value of the year byte.
- R11: The enc_* outputs change only on a valid encode, and the dec_* outputs change only on a valid decode. Both sets hold their values while in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input fields valid this cycle |
| dir_decode | input | 1 | 0 = binary to BCD, 1 = BCD to binary |
| mode_12h | input | 1 | 1 = 12-hour hour byte with PM flag, 0 = 24-hour |
| bin_year | input | 12 | Binary full year (encode) |
| bin_month | input | 7 | Binary month 1..12 (encode) |
| bin_day | input | 7 | Binary day (encode) |
| bin_hour | input | 7 | Binary hour 0..23 (encode) |
| bin_min | input | 7 | Binary minute (encode) |
| bin_sec | input | 7 | Binary second (encode) |
| reg_year | input | 8 | BCD year byte (decode) |
| reg_month | input | 8 | Month byte with century flag in bit 7 (decode) |
| reg_day | input | 8 | BCD day byte (decode) |
| reg_hour | input | 8 | Hour byte (decode) |
| reg_min | input | 8 | BCD minute byte (decode) |
| reg_sec | input | 8 | BCD second byte (decode) |
| out_valid | output | 1 | Result registered this cycle |
| enc_year | output | 8 | Encoded year byte |
| enc_month | output | 8 | Encoded month byte |
| enc_day | output | 8 | Encoded day byte |
| enc_hour | output | 8 | Encoded hour byte |
| enc_min | output | 8 | Encoded minute byte |
| enc_sec | output | 8 | Encoded second byte |
| dec_year | output | 12 | Decoded full year |
| dec_month | output | 7 | Decoded month |
| dec_day | output | 7 | Decoded day |
| dec_hour | output | 7 | Decoded 24-hour value |
| dec_min | output | 7 | Decoded minute |
| dec_sec | output | 7 | Decoded second |

## Verification
The block holds no state apart from its output registers, so a fault in the conversion logic shows up on the result bytes in the very cycle after the input that exposes it. Two inputs are the sharpest probes: the hours near the 12-hour fold (0, 11, 12, 13, 23), and years on either side of 2000 for the century flag. A fault in the update enables would show as one result set changing after an operation in the other direction, or after an idle cycle. The tests therefore compare both result sets one cycle after every operation.

// File: rtl/rtc_bcd_pkg.sv
// Package: shared widths and bit positions of the packed clock register bytes.
// Assumes every packed byte is {tens, units} and that field values stay below 100.
package rtc_bcd_pkg;
    localparam int BYTE_W     = 8;   // width of one clock register byte
    localparam int PM_BIT     = 5;   // hour byte, 12-hour layout: afternoon flag
    localparam int CENT_BIT   = 7;   // month byte: year is 2000 or later
    localparam int N_PLAIN    = 3;   // fields with no extra flag: second, minute, day
    localparam int IDX_SEC    = 0;
    localparam int IDX_MIN    = 1;
    localparam int IDX_DAY    = 2;
endpackage

// File: rtl/rtc_bin2bcd.sv
// Binary to two-digit packed BCD. Assumes input 0..99; the tens digit
// comes from a multiply-by-205 and shift-by-11 reciprocal, exact on that range.
module rtc_bin2bcd #(
    parameter int FW = 7
) (
    input  logic [FW-1:0] bin,
    output logic [7:0]    bcd
);
    localparam int PW = FW + 9;

    logic [3:0] tens;
    logic [3:0] units;

    // Split the value into tens and units digits.
    always_comb begin
        tens  = 4'((PW'(bin) * PW'(205)) >> 11);
        units = 4'(bin - FW'(tens) * FW'(10));
        bcd   = {tens, units};
    end
endmodule

// File: rtl/rtc_bcd2bin.sv
// Packed BCD byte to binary. Assumes both digits are decimal (0..9).
module rtc_bcd2bin #(
    parameter int FW = 7
) (
    input  logic [7:0]    bcd,
    output logic [FW-1:0] bin
);
    // Weight the tens digit by ten and add the units digit.
    always_comb begin
        bin = FW'(bcd[7:4]) * FW'(10) + FW'(bcd[3:0]);
    end
endmodule

// File: rtl/rtc_hour_map.sv
// Hour codec for both directions. In 12-hour layout it folds a 0..23 binary hour
// onto 1..12 with the afternoon flag and unfolds the byte back. In 24-hour
// layout it is plain BCD. Assumes binary hours 0..23 and decimal digits.
module rtc_hour_map
    import rtc_bcd_pkg::*;
#(
    parameter int FW = 7
) (
    input  logic              mode_12h,
    input  logic [FW-1:0]     bin_hour,
    input  logic [BYTE_W-1:0] hour_byte,
    output logic [BYTE_W-1:0] enc_byte,
    output logic [FW-1:0]     dec_hour
);
    logic [FW-1:0]     fold_hour;
    logic [FW-1:0]     enc_src;
    logic [BYTE_W-1:0] enc_bcd;
    logic              enc_pm;
    logic [BYTE_W-1:0] dec_src;
    logic [FW-1:0]     dec_raw;
    logic              dec_pm;

    // Fold the binary hour to 1..12 and note the afternoon half.
    always_comb begin
        enc_pm = (bin_hour >= FW'(12));
        if (bin_hour == '0)
            fold_hour = FW'(12);
        else if (bin_hour > FW'(12))
            fold_hour = bin_hour - FW'(12);
        else
            fold_hour = bin_hour;
        enc_src = mode_12h ? fold_hour : bin_hour;
    end

    rtc_bin2bcd #(.FW(FW)) u_enc (
        .bin (enc_src),
        .bcd (enc_bcd)
    );

    // Place the afternoon flag into the encoded byte in 12-hour layout.
    always_comb begin
        enc_byte = enc_bcd;
        if (mode_12h)
            enc_byte[PM_BIT] = enc_pm;
    end

    // Strip the afternoon flag before the digits are converted.
    always_comb begin
        dec_pm  = hour_byte[PM_BIT];
        dec_src = hour_byte;
        if (mode_12h)
            dec_src[PM_BIT] = 1'b0;
    end

    rtc_bcd2bin #(.FW(FW)) u_dec (
        .bcd (dec_src),
        .bin (dec_raw)
    );

    // Unfold 1..12 with the flag back onto 0..23.
    always_comb begin
        if (mode_12h)
            dec_hour = (dec_raw % FW'(12)) + (dec_pm ? FW'(12) : FW'(0));
        else
            dec_hour = dec_raw;
    end
endmodule

// File: rtl/rtc_bcd_conv.sv
// Top: converts calendar fields between binary and clock register bytes in
// either direction and registers the result one cycle after in_valid.
// Assumes binary fields 0..99 (hour 0..23, month 1..12) and decimal digits.
module rtc_bcd_conv
    import rtc_bcd_pkg::*;
#(
    parameter int FW           = 7,
    parameter int YEAR_W       = 12,
    parameter int EPOCH        = 2000,
    parameter int CENTURY_BASE = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dir_decode,
    input  logic              mode_12h,
    input  logic [YEAR_W-1:0] bin_year,
    input  logic [FW-1:0]     bin_month,
    input  logic [FW-1:0]     bin_day,
    input  logic [FW-1:0]     bin_hour,
    input  logic [FW-1:0]     bin_min,
    input  logic [FW-1:0]     bin_sec,
    input  logic [7:0]        reg_year,
    input  logic [7:0]        reg_month,
    input  logic [7:0]        reg_day,
    input  logic [7:0]        reg_hour,
    input  logic [7:0]        reg_min,
    input  logic [7:0]        reg_sec,
    output logic              out_valid,
    output logic [7:0]        enc_year,
    output logic [7:0]        enc_month,
    output logic [7:0]        enc_day,
    output logic [7:0]        enc_hour,
    output logic [7:0]        enc_min,
    output logic [7:0]        enc_sec,
    output logic [YEAR_W-1:0] dec_year,
    output logic [FW-1:0]     dec_month,
    output logic [FW-1:0]     dec_day,
    output logic [FW-1:0]     dec_hour,
    output logic [FW-1:0]     dec_min,
    output logic [FW-1:0]     dec_sec
);
    logic [FW-1:0]     pl_bin  [N_PLAIN];
    logic [BYTE_W-1:0] pl_byte [N_PLAIN];
    logic [BYTE_W-1:0] pl_enc  [N_PLAIN];
    logic [FW-1:0]     pl_dec  [N_PLAIN];

    logic [FW-1:0]     yy_bin;
    logic              century;
    logic [BYTE_W-1:0] yy_enc;
    logic [FW-1:0]     yy_dec;
    logic [BYTE_W-1:0] mon_bcd;
    logic [BYTE_W-1:0] mon_enc;
    logic [BYTE_W-1:0] mon_src;
    logic [FW-1:0]     mon_dec;
    logic [BYTE_W-1:0] hr_enc;
    logic [FW-1:0]     hr_dec;
    logic              do_enc;
    logic              do_dec;

    assign pl_bin[IDX_SEC]  = bin_sec;
    assign pl_bin[IDX_MIN]  = bin_min;
    assign pl_bin[IDX_DAY]  = bin_day;
    assign pl_byte[IDX_SEC] = reg_sec;
    assign pl_byte[IDX_MIN] = reg_min;
    assign pl_byte[IDX_DAY] = reg_day;

    // One converter pair for each field that carries no flag.
    for (genvar gi = 0; gi < N_PLAIN; gi++) begin : g_plain
        rtc_bin2bcd #(.FW(FW)) u_enc (
            .bin (pl_bin[gi]),
            .bcd (pl_enc[gi])
        );
        rtc_bcd2bin #(.FW(FW)) u_dec (
            .bcd (pl_byte[gi]),
            .bin (pl_dec[gi])
        );
    end

    rtc_hour_map #(.FW(FW)) u_hour (
        .mode_12h  (mode_12h),
        .bin_hour  (bin_hour),
        .hour_byte (reg_hour),
        .enc_byte  (hr_enc),
        .dec_hour  (hr_dec)
    );

    // Reduce the full year to two digits and derive the century flag.
    always_comb begin
        yy_bin  = FW'(bin_year % YEAR_W'(100));
        century = (bin_year >= YEAR_W'(CENTURY_BASE));
    end

    rtc_bin2bcd #(.FW(FW)) u_yy_enc (
        .bin (yy_bin),
        .bcd (yy_enc)
    );
    rtc_bcd2bin #(.FW(FW)) u_yy_dec (
        .bcd (reg_year),
        .bin (yy_dec)
    );
    rtc_bin2bcd #(.FW(FW)) u_mon_enc (
        .bin (bin_month),
        .bcd (mon_bcd)
    );

    // Fold the century flag into the month byte; strip it before decoding.
    always_comb begin
        mon_enc           = mon_bcd;
        mon_enc[CENT_BIT] = century;
        mon_src           = reg_month;
        mon_src[CENT_BIT] = 1'b0;
    end

    rtc_bcd2bin #(.FW(FW)) u_mon_dec (
        .bcd (mon_src),
        .bin (mon_dec)
    );

    assign do_enc = in_valid && !dir_decode;
    assign do_dec = in_valid &&  dir_decode;

    // Output stage: each result set loads only for its own direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            enc_year  <= '0;
            enc_month <= '0;
            enc_day   <= '0;
            enc_hour  <= '0;
            enc_min   <= '0;
            enc_sec   <= '0;
            dec_year  <= '0;
            dec_month <= '0;
            dec_day   <= '0;
            dec_hour  <= '0;
            dec_min   <= '0;
            dec_sec   <= '0;
        end else begin
            out_valid <= in_valid;
            if (do_enc) begin
                enc_year  <= yy_enc;
                enc_month <= mon_enc;
                enc_day   <= pl_enc[IDX_DAY];
                enc_hour  <= hr_enc;
                enc_min   <= pl_enc[IDX_MIN];
                enc_sec   <= pl_enc[IDX_SEC];
            end
            if (do_dec) begin
                dec_year  <= YEAR_W'(EPOCH) + YEAR_W'(yy_dec);
                dec_month <= mon_dec;
                dec_day   <= pl_dec[IDX_DAY];
                dec_hour  <= hr_dec;
                dec_min   <= pl_dec[IDX_MIN];
                dec_sec   <= pl_dec[IDX_SEC];
            end
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R2
    AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || dir_decode) |=> $stable({enc_year, enc_month, enc_day, enc_hour, enc_min, enc_sec}));  // R11
    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || !dir_decode) |=> $stable({dec_year, dec_month, dec_day, dec_hour, dec_min, dec_sec}));  // R11
    AST_CENTURY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (do_enc && bin_year >= YEAR_W'(CENTURY_BASE)) |=> enc_month[CENT_BIT]);  // R6
    AST_HOUR12_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (do_enc && mode_12h && bin_hour < FW'(24)) |=> (enc_hour[4:0] != 5'd0));  // R5
endmodule

// File: tb/rtc_bcd_conv_test.sv
module rtc_bcd_conv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dir_decode = 1'b0;
    logic        mode_12h = 1'b0;
    logic [11:0] bin_year = '0;
    logic [6:0]  bin_month = '0, bin_day = '0, bin_hour = '0, bin_min = '0, bin_sec = '0;
    logic [7:0]  reg_year = '0, reg_month = '0, reg_day = '0, reg_hour = '0, reg_min = '0, reg_sec = '0;
    logic        out_valid;
    logic [7:0]  enc_year, enc_month, enc_day, enc_hour, enc_min, enc_sec;
    logic [11:0] dec_year;
    logic [6:0]  dec_month, dec_day, dec_hour, dec_min, dec_sec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    rtc_bcd_conv uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_decode(dir_decode),
        .mode_12h(mode_12h), .bin_year(bin_year), .bin_month(bin_month),
        .bin_day(bin_day), .bin_hour(bin_hour), .bin_min(bin_min), .bin_sec(bin_sec),
        .reg_year(reg_year), .reg_month(reg_month), .reg_day(reg_day),
        .reg_hour(reg_hour), .reg_min(reg_min), .reg_sec(reg_sec),
        .out_valid(out_valid), .enc_year(enc_year), .enc_month(enc_month),
        .enc_day(enc_day), .enc_hour(enc_hour), .enc_min(enc_min), .enc_sec(enc_sec),
        .dec_year(dec_year), .dec_month(dec_month), .dec_day(dec_day),
        .dec_hour(dec_hour), .dec_min(dec_min), .dec_sec(dec_sec)
    );

    function automatic int to_bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int from_bcd(int b);
        return ((b >> 4) & 15) * 10 + (b & 15);
    endfunction

    function automatic int exp_h12_byte(int h);
        int f = ((h + 11) % 12) + 1;
        return to_bcd(f) | ((h >= 12) ? 32 : 0);
    endfunction

    function automatic int exp_h12_dec(int b);
        return (from_bcd(b & 8'hDF) % 12) + (((b & 32) != 0) ? 12 : 0);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Present one operation for one cycle, then return with outputs settled.
    task automatic run_op(bit dec, bit m12);
        @(negedge clk);
        dir_decode = dec;
        mode_12h = m12;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        chk("R2 valid high", int'(out_valid), 1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_enc(bit m12, int y, int mo, int d, int h, int mi, int s);
        bin_year = 12'(y); bin_month = 7'(mo); bin_day = 7'(d);
        bin_hour = 7'(h); bin_min = 7'(mi); bin_sec = 7'(s);
        run_op(1'b0, m12);
    endtask

    task automatic do_dec(bit m12, int y, int mo, int d, int h, int mi, int s);
        reg_year = 8'(y); reg_month = 8'(mo); reg_day = 8'(d);
        reg_hour = 8'(h); reg_min = 8'(mi); reg_sec = 8'(s);
        run_op(1'b1, m12);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 enc", int'({enc_year, enc_month, enc_day, enc_hour, enc_min, enc_sec} != 0), 0);
        chk("R1 dec", int'({dec_year, dec_month, dec_day, dec_hour, dec_min, dec_sec} != 0), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_plain_encode();
        int vals[4] = '{0, 9, 37, 59};
        foreach (vals[i]) begin
            do_enc(1'b0, 2010, 3, vals[i], 5, vals[3-i], vals[i]);
            chk("R3 sec", int'(enc_sec), to_bcd(vals[i]));
            chk("R3 min", int'(enc_min), to_bcd(vals[3-i]));
            chk("R3 day", int'(enc_day), to_bcd(vals[i]));
        end
        chk("R3 59", int'(enc_sec), 8'h59);
    endtask

    task automatic t_hour24_encode();
        int hs[4] = '{0, 9, 12, 23};
        foreach (hs[i]) begin
            do_enc(1'b0, 2020, 1, 1, hs[i], 0, 0);
            chk("R4 hour24", int'(enc_hour), to_bcd(hs[i]));
        end
    endtask

    task automatic t_hour12_encode();
        int hs[7] = '{0, 1, 11, 12, 13, 22, 23};
        foreach (hs[i]) begin
            do_enc(1'b1, 2020, 1, 1, hs[i], 0, 0);
            chk("R5 hour12", int'(enc_hour), exp_h12_byte(hs[i]));
        end
        do_enc(1'b1, 2020, 1, 1, 0, 0, 0);
        chk("R5 midnight 0x12", int'(enc_hour), 8'h12);
        do_enc(1'b1, 2020, 1, 1, 12, 0, 0);
        chk("R5 noon 0x32", int'(enc_hour), 8'h32);
    endtask

    task automatic t_month_year_encode();
        do_enc(1'b0, 2024, 7, 1, 0, 0, 0);
        chk("R6 month 2024", int'(enc_month), 8'h87);
        chk("R6 year 2024", int'(enc_year), 8'h24);
        do_enc(1'b0, 1999, 12, 1, 0, 0, 0);
        chk("R6 month 1999", int'(enc_month), 8'h12);
        chk("R6 year 1999", int'(enc_year), 8'h99);
        do_enc(1'b0, 2000, 1, 1, 0, 0, 0);
        chk("R6 month 2000", int'(enc_month), 8'h81);
        chk("R6 year 2000", int'(enc_year), 8'h00);
    endtask

    task automatic t_plain_decode();
        do_dec(1'b0, 8'h00, 8'h01, 8'h31, 8'h00, 8'h09, 8'h59);
        chk("R7 sec", int'(dec_sec), 59);
        chk("R7 min", int'(dec_min), 9);
        chk("R7 day", int'(dec_day), 31);
        do_dec(1'b0, 8'h00, 8'h01, 8'h10, 8'h00, 8'h45, 8'h00);
        chk("R7 sec zero", int'(dec_sec), 0);
        chk("R7 min 45", int'(dec_min), 45);
        chk("R7 day 10", int'(dec_day), 10);
    endtask

    task automatic t_hour12_decode();
        int bs[6] = '{8'h12, 8'h01, 8'h11, 8'h32, 8'h21, 8'h31};
        foreach (bs[i]) begin
            do_dec(1'b1, 0, 1, 1, bs[i], 0, 0);
            chk("R8 hour12 decode", int'(dec_hour), exp_h12_dec(bs[i]));
        end
        chk("R8 0x31 is 23", int'(dec_hour), 23);
    endtask

    task automatic t_hour24_decode();
        int bs[3] = '{8'h00, 8'h12, 8'h23};
        foreach (bs[i]) begin
            do_dec(1'b0, 0, 1, 1, bs[i], 0, 0);
            chk("R9 hour24 decode", int'(dec_hour), from_bcd(bs[i]));
        end
    endtask

    task automatic t_month_year_decode();
        do_dec(1'b0, 8'h24, 8'h87, 1, 0, 0, 0);
        chk("R10 month flag masked", int'(dec_month), 7);
        chk("R10 year epoch", int'(dec_year), 2024);
        do_dec(1'b0, 8'h99, 8'h12, 1, 0, 0, 0);
        chk("R10 month 12", int'(dec_month), 12);
        chk("R10 year 2099", int'(dec_year), 2099);
    endtask

    task automatic t_hold();
        do_enc(1'b0, 2031, 11, 28, 17, 42, 5);
        chk("R11 enc loaded", int'(enc_min), 8'h42);
        do_dec(1'b0, 8'h07, 8'h03, 8'h15, 8'h08, 8'h33, 8'h21);
        chk("R11 enc kept on decode", int'({enc_year, enc_month, enc_hour, enc_min}), int'({8'h31, 8'h91, 8'h17, 8'h42}));
        chk("R11 dec loaded", int'(dec_min), 33);
        do_enc(1'b0, 2050, 2, 2, 2, 2, 2);
        chk("R11 dec kept on encode", int'(dec_min), 33);
        chk("R11 dec year kept", int'(dec_year), 2007);
        // Idle cycles with changed inputs must touch nothing.
        bin_min = 7'd58; reg_min = 8'h11; dir_decode = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R2 valid low", int'(out_valid), 0);
        chk("R11 idle enc", int'(enc_min), 8'h02);
        chk("R11 idle dec", int'(dec_min), 33);
    endtask

    initial begin
        t_reset();
        t_plain_encode();
        t_hour24_encode();
        t_hour12_encode();
        t_month_year_encode();
        t_plain_decode();
        t_hour12_decode();
        t_hour24_decode();
        t_month_year_decode();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule